// File: doc/BRIEF.md
# Configuration Header Base Address Register File

This block is the device-side part of a configuration header that holds the identification dword and six base address registers. A host reaches it by dword register number, with one enable per byte. It uses the registers to find the device, size each decoded region and then place each region in the system address map. Every base address register is set at build time as unused, as an I/O window or as a memory window, and is given a power-of-two size. Only the address bits above that size can be written. So when the host writes all ones, the value it reads back is the region's size mask, with the fixed type bits in the low positions.

Once the host has programmed the bases, the block drives them on a flat output bus. It also compares a probe address against every region, with the low size bits masked off, and raises a one-hot hit flag for each region. Read data and hit flags are registered and appear one clock after the request or the probe. Command and status registers and the vendor-specific area are not part of this block.

Top module: `cfg_bar_file`

## Requirements
- R1: Register number 0 reads as {DEVICE_ID, VENDOR_ID}, with the device ID in bits 31:16. Writes to register number 0 have no effect.
- R2: A read request (cfg_req=1, cfg_we=0) returns its data on cfg_rdata with cfg_rvalid=1 in the next cycle. cfg_rvalid is 0 in the cycle after a write or an idle cycle. Register numbers other than 0 and 4 to 9 read as zero.
- R3: Base address register k sits at register number 4+k (byte offsets 10h to 24h). After all ones are written to it, it reads back the size mask ORed with its fixed low bits. A 64 KB memory region therefore reads FFFF0000h.
- R4: An I/O region reads bits 1:0 as 01. A memory region reads bit 0 as 0 and bits 3:1 as its attribute parameter. All other bits below the region size read 0.
- R5: A base written into the writable bits is held and read back. bar_base slice k (bits 32k+31:32k) equals the writable bits of register k, with zeros below the size.
- R6: A write changes only the bytes whose cfg_be bit is set (bit b covers bits 8b+7:8b). Read-only bits never change.
- R7: An unused base address register (kind 0) reads all zeros, ignores writes, shows zero on bar_base and never raises its hit flag.
- R8: Region size is 2^SZLOG bytes, raised to at least 4 bytes for I/O (kind 1) and at least 16 bytes for memory (kind 2).
- R9: bar_hit[k] is 1 one cycle after a probe when all of the following hold: probe_is_io matches the region kind (1 for I/O, 0 for memory), the probe address ANDed with the size mask equals the stored base, and the region is used.
- R10: A synchronous reset clears every base to zero, and clears cfg_rdata, cfg_rvalid and bar_hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration access valid this cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_regnum | input | REGW | Dword register number |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid |
| probe_addr | input | 32 | Address checked against the regions |
| probe_is_io | input | 1 | Probe is an I/O access (1) or memory access (0) |
| bar_base | output | 32*NBARS | Programmed bases, register k in slice k |
| bar_hit | output | NBARS | Per-region hit flags |

## Verification
The bench does not use the default parameters. It builds the block with an I/O region of 256 bytes, an I/O region of 16 bytes, a 64 KB memory region, a memory region whose requested size of 4 bytes is raised to 16 bytes, an I/O region whose requested size of 1 byte is raised to 4 bytes, and one unused slot. That mix lets one build reach both minimum-size clamps, a memory attribute field that is not zero, the 64 KB sizing readback and the unused-slot behaviour. Random register accesses with random byte enables, together with probes placed inside, near and outside each programmed window, are checked against a model of the stored bases.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;
  localparam int unsigned CFG_DW = 32;
  localparam int unsigned CFG_NB = CFG_DW / 8;

  typedef enum logic [1:0] {
    BAR_NONE = 2'd0,
    BAR_IO   = 2'd1,
    BAR_MEM  = 2'd2
  } bar_kind_e;

  // Effective size exponent after kind-dependent minimum clamping.
  function automatic int unsigned bar_eff_log(input logic [1:0] kind, input int unsigned szlog);
    int unsigned s;
    s = szlog;
    if (kind == BAR_IO && s < 2) s = 2;
    if (kind == BAR_MEM && s < 4) s = 4;
    if (s > 31) s = 31;
    return s;
  endfunction

  // Writable address bits of a region.
  function automatic logic [CFG_DW-1:0] bar_wmask(input logic [1:0] kind, input int unsigned szlog);
    if (kind != BAR_IO && kind != BAR_MEM) return '0;
    return {CFG_DW{1'b1}} << bar_eff_log(kind, szlog);
  endfunction

  // Constant low bits reported on readback.
  function automatic logic [CFG_DW-1:0] bar_fixed(input logic [1:0] kind, input logic [2:0] attr);
    logic [CFG_DW-1:0] v;
    v = '0;
    if (kind == BAR_IO) v[1:0] = 2'b01;
    else if (kind == BAR_MEM) v[3:0] = {attr, 1'b0};
    return v;
  endfunction
endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
  parameter logic [1:0]  KIND  = 2'd0,
  parameter int unsigned SZLOG = 0,
  parameter logic [2:0]  ATTR  = 3'd0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [cfg_bar_pkg::CFG_NB-1:0]      be,
  input  logic [cfg_bar_pkg::CFG_DW-1:0]      wdata,
  output logic [cfg_bar_pkg::CFG_DW-1:0]      rd_value,
  output logic [cfg_bar_pkg::CFG_DW-1:0]      base
);
  import cfg_bar_pkg::*;

  localparam logic [CFG_DW-1:0] WMASK = bar_wmask(KIND, SZLOG);
  localparam logic [CFG_DW-1:0] FIXED = bar_fixed(KIND, ATTR);
  localparam bit                USED  = (KIND == BAR_IO) || (KIND == BAR_MEM);

  generate
    if (USED) begin : g_used
      logic [CFG_DW-1:0] base_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          base_q <= '0;
        end else if (wr_en) begin
          for (int b = 0; b < CFG_NB; b++) begin
            if (be[b]) base_q[8*b +: 8] <= wdata[8*b +: 8] & WMASK[8*b +: 8];
          end
        end
      end

      assign base     = base_q & WMASK;
      assign rd_value = (base_q & WMASK) | FIXED;
    end else begin : g_unused
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst, wr_en, be, wdata};
      assign base      = '0;
      assign rd_value  = '0;
    end
  endgenerate
endmodule

// File: rtl/cfg_bar_match.sv
module cfg_bar_match #(
  parameter logic [1:0]  KIND  = 2'd0,
  parameter int unsigned SZLOG = 0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [cfg_bar_pkg::CFG_DW-1:0] probe_addr,
  input  logic                           probe_is_io,
  input  logic [cfg_bar_pkg::CFG_DW-1:0] base,
  output logic                           hit
);
  import cfg_bar_pkg::*;

  localparam logic [CFG_DW-1:0] WMASK = bar_wmask(KIND, SZLOG);
  localparam bit USED   = (KIND == BAR_IO) || (KIND == BAR_MEM);
  localparam bit IS_IO  = (KIND == BAR_IO);

  logic space_ok;
  logic addr_ok;

  assign space_ok = (probe_is_io == IS_IO);
  assign addr_ok  = ((probe_addr & WMASK) == base);

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= USED && space_ok && addr_ok;
  end
endmodule

// File: rtl/cfg_bar_rdmux.sv
module cfg_bar_rdmux #(
  parameter int unsigned NBARS     = 6,
  parameter int unsigned REGW      = 6,
  parameter int unsigned BAR_FIRST = 4
) (
  input  logic [REGW-1:0]                          regnum,
  input  logic [cfg_bar_pkg::CFG_DW-1:0]           id_word,
  input  logic [NBARS*cfg_bar_pkg::CFG_DW-1:0]     bar_words,
  output logic [cfg_bar_pkg::CFG_DW-1:0]           value
);
  import cfg_bar_pkg::*;

  always_comb begin
    value = '0;
    if (regnum == '0) value = id_word;
    for (int i = 0; i < NBARS; i++) begin
      if (regnum == REGW'(BAR_FIRST + i)) value = bar_words[CFG_DW*i +: CFG_DW];
    end
  end
endmodule

// File: rtl/cfg_bar_file.sv
module cfg_bar_file #(
  parameter logic [15:0]  VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0]  DEVICE_ID  = 16'h7E21,
  parameter int unsigned  NBARS      = 6,
  parameter int unsigned  REGW       = 6,
  parameter logic [2*NBARS-1:0] BAR_KIND  = {2'd0, 2'd0, 2'd2, 2'd2, 2'd1, 2'd1},
  parameter logic [6*NBARS-1:0] BAR_SZLOG = {6'd0, 6'd0, 6'd12, 6'd16, 6'd4, 6'd8},
  parameter logic [3*NBARS-1:0] BAR_ATTR  = {3'd0, 3'd0, 3'd4, 3'd0, 3'd0, 3'd0}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_req,
  input  logic                    cfg_we,
  input  logic [REGW-1:0]         cfg_regnum,
  input  logic [3:0]              cfg_be,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  output logic                    cfg_rvalid,
  input  logic [31:0]             probe_addr,
  input  logic                    probe_is_io,
  output logic [32*NBARS-1:0]     bar_base,
  output logic [NBARS-1:0]        bar_hit
);
  import cfg_bar_pkg::*;

  localparam int unsigned BAR_FIRST = 4;
  localparam logic [CFG_DW-1:0] ID_WORD = {DEVICE_ID, VENDOR_ID};

  logic [NBARS*CFG_DW-1:0] bar_words;
  logic [CFG_DW-1:0]       rd_next;
  logic                    do_write;

  assign do_write = cfg_req && cfg_we;

  generate
    for (genvar i = 0; i < NBARS; i++) begin : g_bar
      logic sel_wr;
      assign sel_wr = do_write && (cfg_regnum == REGW'(BAR_FIRST + i));

      cfg_bar_slot #(
        .KIND  (BAR_KIND[2*i +: 2]),
        .SZLOG (int'(BAR_SZLOG[6*i +: 6])),
        .ATTR  (BAR_ATTR[3*i +: 3])
      ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (sel_wr),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .rd_value (bar_words[CFG_DW*i +: CFG_DW]),
        .base     (bar_base[CFG_DW*i +: CFG_DW])
      );

      cfg_bar_match #(
        .KIND  (BAR_KIND[2*i +: 2]),
        .SZLOG (int'(BAR_SZLOG[6*i +: 6]))
      ) u_match (
        .clk         (clk),
        .rst         (rst),
        .probe_addr  (probe_addr),
        .probe_is_io (probe_is_io),
        .base        (bar_base[CFG_DW*i +: CFG_DW]),
        .hit         (bar_hit[i])
      );
    end
  endgenerate

  cfg_bar_rdmux #(
    .NBARS     (NBARS),
    .REGW      (REGW),
    .BAR_FIRST (BAR_FIRST)
  ) u_rdmux (
    .regnum    (cfg_regnum),
    .id_word   (ID_WORD),
    .bar_words (bar_words),
    .value     (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= cfg_req && !cfg_we;
      if (cfg_req && !cfg_we) cfg_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/cfg_bar_chk.sv
module cfg_bar_chk #(
  parameter logic [15:0]  VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0]  DEVICE_ID  = 16'h7E21,
  parameter int unsigned  NBARS      = 6,
  parameter int unsigned  REGW       = 6,
  parameter logic [2*NBARS-1:0] BAR_KIND  = '0,
  parameter logic [6*NBARS-1:0] BAR_SZLOG = '0,
  parameter logic [3*NBARS-1:0] BAR_ATTR  = '0
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_req,
  input logic                cfg_we,
  input logic [REGW-1:0]     cfg_regnum,
  input logic [3:0]          cfg_be,
  input logic [31:0]         cfg_wdata,
  input logic [31:0]         cfg_rdata,
  input logic                cfg_rvalid,
  input logic [31:0]         probe_addr,
  input logic                probe_is_io,
  input logic [32*NBARS-1:0] bar_base,
  input logic [NBARS-1:0]    bar_hit
);
  import cfg_bar_pkg::*;

  assert_rvalid_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_we) |=> cfg_rvalid);

  assert_no_rvalid_otherwise_R2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req && !cfg_we) |=> !cfg_rvalid);

  assert_id_readback_R1: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_we && cfg_regnum == '0) |=> (cfg_rdata == {DEVICE_ID, VENDOR_ID}));

  assert_bases_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req && cfg_we) |=> $stable(bar_base));

  generate
    for (genvar i = 0; i < NBARS; i++) begin : g_chk
      localparam logic [31:0] WM = bar_wmask(BAR_KIND[2*i +: 2], int'(BAR_SZLOG[6*i +: 6]));
      localparam logic [31:0] FX = bar_fixed(BAR_KIND[2*i +: 2], BAR_ATTR[3*i +: 3]);
      localparam bit USED = (BAR_KIND[2*i +: 2] == 2'd1) || (BAR_KIND[2*i +: 2] == 2'd2);

      assert_fixed_low_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_we && cfg_regnum == REGW'(4 + i)) |=> ((cfg_rdata & ~WM) == FX));

      assert_read_matches_base_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_we && cfg_regnum == REGW'(4 + i))
          |=> ((cfg_rdata & WM) == $past(bar_base[32*i +: 32])));

      if (!USED) begin : g_unused
        assert_unused_quiet_R7: assert property (@(posedge clk) disable iff (rst)
          !bar_hit[i] && (bar_base[32*i +: 32] == '0));
      end
    end
  endgenerate
endmodule

bind cfg_bar_file cfg_bar_chk #(
  .VENDOR_ID (VENDOR_ID),
  .DEVICE_ID (DEVICE_ID),
  .NBARS     (NBARS),
  .REGW      (REGW),
  .BAR_KIND  (BAR_KIND),
  .BAR_SZLOG (BAR_SZLOG),
  .BAR_ATTR  (BAR_ATTR)
) u_cfg_bar_chk (.*);

// File: tb/tb_cfg_bar_file.sv
`timescale 1ns/1ps
module tb_cfg_bar_file;
  localparam int NB = 6;
  localparam logic [15:0] VID = 16'h4C1B;
  localparam logic [15:0] DID = 16'h90E7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_req = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cfg_regnum = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic [31:0] probe_addr = '0;
  logic        probe_is_io = 1'b0;
  logic [32*NB-1:0] bar_base;
  logic [NB-1:0]    bar_hit;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_bar_file #(
    .VENDOR_ID (VID), .DEVICE_ID (DID), .NBARS (NB), .REGW (6),
    .BAR_KIND  ({2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd1}),
    .BAR_SZLOG ({6'd0, 6'd0, 6'd2, 6'd16, 6'd4, 6'd8}),
    .BAR_ATTR  ({3'd0, 3'd0, 3'd4, 3'd0, 3'd0, 3'd0})
  ) dut (.*);

  // Expected sizes and fixed bits from the requirements (R3, R4, R8).
  logic [31:0] mask_t [NB] = '{32'hFFFFFF00, 32'hFFFFFFF0, 32'hFFFF0000,
                               32'hFFFFFFF0, 32'hFFFFFFFC, 32'h00000000};
  logic [31:0] fix_t  [NB] = '{32'h1, 32'h1, 32'h0, 32'h8, 32'h1, 32'h0};
  bit          io_t   [NB] = '{1, 1, 0, 0, 1, 0};
  bit          used_t [NB] = '{1, 1, 1, 1, 1, 0};
  logic [31:0] model  [NB];

  function automatic logic [31:0] exp_read(input int r);
    if (r == 0) return {DID, VID};
    if (r >= 4 && r <= 9) return (model[r-4] & mask_t[r-4]) | fix_t[r-4];
    return 32'h0;
  endfunction

  function automatic logic [NB-1:0] exp_hit(input logic [31:0] a, input bit io);
    logic [NB-1:0] h;
    for (int i = 0; i < NB; i++)
      h[i] = used_t[i] && (io_t[i] == io) && ((a & mask_t[i]) == model[i]);
    return h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cfg_op(input bit we, input int r, input logic [3:0] be,
                        input logic [31:0] d, input string req);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_regnum = 6'(r); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    if (we) begin
      chk({req, " rvalid low after write"}, 32'(cfg_rvalid), 32'h0);
      if (r >= 4 && r <= 9)
        for (int b = 0; b < 4; b++)
          if (be[b]) model[r-4][8*b +: 8] = d[8*b +: 8] & mask_t[r-4][8*b +: 8];
    end else begin
      chk({req, " rvalid"}, 32'(cfg_rvalid), 32'h1);
      chk(req, cfg_rdata, exp_read(r));
    end
    cfg_req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input bit io, input string req);
    @(negedge clk);
    probe_addr = a; probe_is_io = io;
    @(negedge clk);
    chk(req, 32'(bar_hit), 32'(exp_hit(a, io)));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rdata", cfg_rdata, 32'h0);
    chk("R10 rvalid", 32'(cfg_rvalid), 32'h0);
    chk("R10 hit", 32'(bar_hit), 32'h0);
    for (int i = 0; i < NB; i++) chk("R10 base", bar_base[32*i +: 32], 32'h0);
    rst = 1'b0;

    cfg_op(0, 0, 4'hF, 0, "R1 id read");
    cfg_op(1, 0, 4'hF, 32'hFFFFFFFF, "R1 id write");
    cfg_op(0, 0, 4'hF, 0, "R1 id unchanged");

    // Sizing on every slot (R3, R4, R7, R8)
    for (int i = 0; i < NB; i++) begin
      cfg_op(1, 4 + i, 4'hF, 32'hFFFFFFFF, "R3 size write");
      cfg_op(0, 4 + i, 4'hF, 0, "R3 R4 R8 size read");
    end
    chk("R3 64KB readback", (model[2] & mask_t[2]) | fix_t[2], 32'hFFFF0000);
    cfg_op(0, 6, 4'hF, 0, "R3 64KB memory region");
    cfg_op(0, 7, 4'hF, 0, "R8 memory min 16 bytes with attr");
    cfg_op(0, 8, 4'hF, 0, "R8 io min 4 bytes");
    cfg_op(0, 9, 4'hF, 0, "R7 unused reads zero");
    chk("R8 mem clamp value", exp_read(7), 32'hFFFFFFF8);
    chk("R8 io clamp value", exp_read(8), 32'hFFFFFFFD);

    // Programming (R5)
    cfg_op(1, 4, 4'hF, 32'h0000C100, "R5 prog");
    cfg_op(1, 5, 4'hF, 32'h0000D01F, "R5 prog low bits");
    cfg_op(1, 6, 4'hF, 32'h80010000, "R5 prog");
    cfg_op(1, 7, 4'hF, 32'h90000040, "R5 prog");
    cfg_op(1, 8, 4'hF, 32'h0000E004, "R5 prog");
    cfg_op(1, 9, 4'hF, 32'h12345678, "R7 unused write");
    for (int i = 0; i < NB; i++) begin
      cfg_op(0, 4 + i, 4'hF, 0, "R5 readback");
      chk("R5 base out", bar_base[32*i +: 32], model[i]);
    end
    chk("R5 masked low bits", bar_base[63:32], 32'h0000D010);

    // Byte enables (R6)
    cfg_op(1, 6, 4'b1000, 32'h12345678, "R6 top byte");
    cfg_op(0, 6, 4'hF, 0, "R6 top byte read");
    chk("R6 value", bar_base[95:64], 32'h12010000);
    cfg_op(1, 4, 4'b0001, 32'hFFFFFFFF, "R6 read-only byte");
    cfg_op(0, 4, 4'hF, 0, "R6 read-only byte unchanged");

    // Other register numbers (R2)
    cfg_op(0, 2, 4'hF, 0, "R2 hole reg");
    cfg_op(0, 20, 4'hF, 0, "R2 hole reg");
    cfg_op(0, 63, 4'hF, 0, "R2 hole reg");

    // Hits (R9, R7)
    probe(32'h0000C1FF, 1, "R9 io hit");
    probe(32'h0000C1FF, 0, "R9 io addr in mem space");
    probe(32'h12010008, 0, "R9 mem hit");
    probe(32'h12020000, 0, "R9 mem just outside");
    probe(32'h0000E007, 1, "R9 small io edge");
    probe(32'h0000E008, 1, "R9 small io outside");
    probe(32'h00000000, 0, "R7 unused never hits");

    // Random mix
    for (int it = 0; it < 500; it++) begin
      int r; int j;
      r = (($urandom & 3) == 0) ? 0 : int'($urandom_range(15));
      cfg_op($urandom & 1, r, 4'($urandom), $urandom, "R5 R6 random");
      j = $urandom_range(NB - 1);
      probe(($urandom & 1) ? (model[j] | ($urandom & ~mask_t[j])) : $urandom,
            $urandom & 1, "R9 random probe");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule